// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block sits on the receive side of a serial channel, behind the deserializer. The deserializer hands it one finished character at a time, with three error flags: a bad stop bit, a bad parity bit and a line break. The block keeps up to three characters in a small queue. When the queue is full, one more character may wait in a single holding stage. The CPU side pops characters through a read strobe and sees registered status: data ready, queue full, overrun, and the three character error flags.

Error reporting has two modes. In per-character mode, the three error flags follow whichever character is at the head of the queue. In sticky mode, each flag collects every error that enters the queue until software issues the clear-errors strobe. The overrun flag is always sticky. It marks a character lost when a completed character arrives while the queue is full and the holding stage is already occupied.

Top module: `rx_char_fifo`

## Requirements
- R1: Characters leave the queue in arrival order. A read strobe while data is held places the head character on rd_data in the following cycle.
- R2: rxrdy is high whenever at least one character is stored in the queue. It drops only after the read that removes the last stored character.
- R3: ffull is high while all three queue positions are occupied. A read while a character waits in the holding stage leaves ffull high, because that character moves into the freed position in the same cycle.
- R4: A character that completes while the queue is full and the holding stage is empty waits in the holding stage. A further completed character before any read replaces the waiting one, which is lost, and raises ovr_err.
- R5: ovr_err is sticky in both error modes. Only err_clr lowers it.
- R6: With block_mode low, frm_err, par_err and brk_err show the flags of the character currently at the head of the queue, and read 0 while the queue is empty.
- R7: With block_mode high, an error flag rises when a character carrying that error enters the queue. It stays high for all later characters until err_clr.
- R8: A parity error is recorded only if parity_en is high in the cycle the character completes.
- R9: err_clr clears all sticky flags in one cycle. An error entering the queue, or an overrun occurring, in that same cycle wins, and its flag stays high.
- R10: A read strobe while the queue is empty leaves rd_data and all status outputs unchanged.
- R11: After reset, rd_data is 0 and every status output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| block_mode | input | 1 | 1 = sticky error reporting, 0 = per-character |
| parity_en | input | 1 | A parity mode is configured; gates parity errors |
| cmp_valid | input | 1 | A completed character is offered this cycle |
| cmp_data | input | DATA_W | Completed character data |
| cmp_frm | input | 1 | Completed character had a bad stop bit |
| cmp_par | input | 1 | Completed character had a bad parity bit |
| cmp_brk | input | 1 | Completed character was a line break |
| rd_en | input | 1 | CPU read strobe, pops the head character |
| err_clr | input | 1 | Clear-errors command |
| rd_data | output | DATA_W | Last character read |
| rxrdy | output | 1 | Queue holds at least one character |
| ffull | output | 1 | All queue positions occupied |
| ovr_err | output | 1 | Sticky overrun |
| frm_err | output | 1 | Stop-bit error status |
| par_err | output | 1 | Parity error status |
| brk_err | output | 1 | Break status |

## Verification
The bench builds the block with its default values, an 8-bit character and a three-deep queue. The shallow depth lets random traffic reach the full queue, the occupied holding stage and repeated overruns within a few cycles of each other. A read in the same cycle as a new character happens often, so the hand-off from the holding stage under a pending read gets frequent exercise. Switching modes per phase runs both error-reporting schemes against the same queue states.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_err_t;
endpackage

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  rx_err_t           push_err,
  input  logic              pop,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     count_nxt,
  output logic [DATA_W-1:0] head_data,
  output rx_err_t           next_head_err
);
  logic [DATA_W-1:0] mem_d [DEPTH];
  rx_err_t           mem_e [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr, rd_ptr_nxt;
  logic [CW-1:0]     remain;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wr_ptr] <= push_data;
      mem_e[wr_ptr] <= push_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  always_comb begin
    rd_ptr_nxt = pop ? wrap_inc(rd_ptr) : rd_ptr;
    count_nxt  = count + CW'(push) - CW'(pop);
    remain     = count - CW'(pop);
    head_data  = mem_d[rd_ptr];
    if (count_nxt == '0)
      next_head_err = '0;
    else if (remain == '0)
      next_head_err = push_err;
    else
      next_head_err = mem_e[rd_ptr_nxt];
  end
endmodule

// File: rtl/rxf_hold.sv
`timescale 1ns/1ps
module rxf_hold
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_data,
  input  rx_err_t           cmp_err,
  input  logic              full,
  input  logic              pop,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output rx_err_t           push_err,
  output logic              ovr_evt
);
  logic              hold_v;
  logic [DATA_W-1:0] hold_d;
  rx_err_t           hold_e;
  logic              slot_free, hold_to_q, cmp_to_q, cmp_to_hold;

  always_comb begin
    slot_free   = !full || pop;
    hold_to_q   = hold_v && pop;
    cmp_to_q    = cmp_valid && slot_free && !hold_v;
    cmp_to_hold = cmp_valid && !cmp_to_q;
    ovr_evt     = cmp_valid && hold_v && !pop;
    push        = hold_to_q || cmp_to_q;
    push_data   = hold_v ? hold_d : cmp_data;
    push_err    = hold_v ? hold_e : cmp_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      hold_e <= '0;
    end else begin
      hold_v <= (hold_v && !pop) || cmp_to_hold;
      if (cmp_to_hold) begin
        hold_d <= cmp_data;
        hold_e <= cmp_err;
      end
    end
  end
endmodule

// File: rtl/rxf_status.sv
`timescale 1ns/1ps
module rxf_status
  import rxf_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          block_mode,
  input  logic          err_clr,
  input  logic          push,
  input  rx_err_t       push_err,
  input  rx_err_t       next_head_err,
  input  logic          ovr_evt,
  input  logic [CW-1:0] count_nxt,
  output logic          rxrdy,
  output logic          ffull,
  output logic          ovr_err,
  output rx_err_t       err_q
);
  rx_err_t entering, kept, err_nxt;

  always_comb begin
    entering = push ? push_err : '0;
    kept     = err_clr ? '0 : err_q;
    err_nxt  = block_mode ? (kept | entering) : next_head_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxrdy   <= 1'b0;
      ffull   <= 1'b0;
      ovr_err <= 1'b0;
      err_q   <= '0;
    end else begin
      rxrdy   <= (count_nxt != '0);
      ffull   <= (count_nxt == CW'(DEPTH));
      ovr_err <= (ovr_err && !err_clr) || ovr_evt;
      err_q   <= err_nxt;
    end
  end
endmodule

// File: rtl/rx_char_fifo.sv
`timescale 1ns/1ps
module rx_char_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              block_mode,
  input  logic              parity_en,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_frm,
  input  logic              cmp_par,
  input  logic              cmp_brk,
  input  logic              rd_en,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rxrdy,
  output logic              ffull,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              par_err,
  output logic              brk_err
);
  rx_err_t           cmp_err, push_err, next_head_err, err_q;
  logic              push, pop, ovr_evt, full;
  logic [DATA_W-1:0] push_data, head_data;
  logic [CW-1:0]     count, count_nxt;

  always_comb begin
    cmp_err.frm = cmp_frm;
    cmp_err.par = cmp_par && parity_en;
    cmp_err.brk = cmp_brk;
    pop  = rd_en && (count != '0);
    full = (count == CW'(DEPTH));
  end

  rxf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_data(cmp_data),
    .cmp_err(cmp_err), .full(full), .pop(pop), .push(push),
    .push_data(push_data), .push_err(push_err), .ovr_evt(ovr_evt)
  );

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .push_err(push_err), .pop(pop), .count(count), .count_nxt(count_nxt),
    .head_data(head_data), .next_head_err(next_head_err)
  );

  rxf_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst(rst), .block_mode(block_mode), .err_clr(err_clr),
    .push(push), .push_err(push_err), .next_head_err(next_head_err),
    .ovr_evt(ovr_evt), .count_nxt(count_nxt), .rxrdy(rxrdy),
    .ffull(ffull), .ovr_err(ovr_err), .err_q(err_q)
  );

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (pop) rd_data <= head_data;
  end

  always_comb begin
    frm_err = err_q.frm;
    par_err = err_q.par;
    brk_err = err_q.brk;
  end
endmodule

// File: rtl/rxf_checker.sv
`timescale 1ns/1ps
module rxf_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              block_mode,
  input logic              cmp_valid,
  input logic              rd_en,
  input logic              err_clr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rxrdy,
  input logic              ffull,
  input logic              ovr_err,
  input logic              frm_err
);
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst) ffull |-> rxrdy); // R3
  AST_RDY_NO_READ: assert property (@(posedge clk) disable iff (rst) (rxrdy && !rd_en) |=> rxrdy); // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) (ovr_err && !err_clr) |=> ovr_err); // R5
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (rst) (err_clr && !cmp_valid) |=> !ovr_err); // R5
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (rst) (block_mode && frm_err && !err_clr) |=> frm_err); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst) (!rxrdy && rd_en) |=> $stable(rd_data)); // R10
endmodule

bind rx_char_fifo rxf_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rx_char_fifo.sv
`timescale 1ns/1ps
module tb_rx_char_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic block_mode = 1'b0, parity_en = 1'b1;
  logic cmp_valid = 1'b0, cmp_frm = 1'b0, cmp_par = 1'b0, cmp_brk = 1'b0;
  logic [DW-1:0] cmp_data = '0;
  logic rd_en = 1'b0, err_clr = 1'b0;
  logic [DW-1:0] rd_data;
  logic rxrdy, ffull, ovr_err, frm_err, par_err, brk_err;

  always #2.5 clk = ~clk;

  rx_char_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model: entry = {brk, par, frm, data}
  logic [DW+2:0] mq[$];
  logic [DW+2:0] m_hold;
  bit m_hv;
  logic [DW-1:0] m_rd;
  bit m_ovr;
  logic [2:0] m_err; // {brk, par, frm}

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    mq.delete(); m_hv = 0; m_hold = '0; m_rd = '0; m_ovr = 0; m_err = '0;
  endfunction

  function automatic void model_step();
    logic [DW+2:0] nw, pushed;
    bit p, did_push, ovr_evt;
    nw = {cmp_brk, cmp_par & parity_en, cmp_frm, cmp_data};
    did_push = 0; ovr_evt = 0; pushed = '0;
    p = rd_en && (mq.size() > 0);
    if (p) begin m_rd = mq[0][DW-1:0]; void'(mq.pop_front()); end
    if (m_hv && p) begin
      mq.push_back(m_hold); pushed = m_hold; did_push = 1; m_hv = 0;
      if (cmp_valid) begin m_hold = nw; m_hv = 1; end
    end else if (cmp_valid) begin
      if (mq.size() < DEPTH) begin mq.push_back(nw); pushed = nw; did_push = 1; end
      else if (m_hv) begin m_hold = nw; ovr_evt = 1; end
      else begin m_hold = nw; m_hv = 1; end
    end
    m_ovr = (m_ovr && !err_clr) || ovr_evt;
    if (block_mode)
      m_err = (err_clr ? 3'b000 : m_err) | (did_push ? pushed[DW+2:DW] : 3'b000);
    else
      m_err = (mq.size() > 0) ? mq[0][DW+2:DW] : 3'b000;
  endfunction

  task automatic compare_all();
    string et;
    et = block_mode ? "R7" : "R6";
    chk("R1 rd_data", rd_data, m_rd);
    chk("R2 rxrdy", DW'(rxrdy), DW'(mq.size() > 0));
    chk("R3 ffull", DW'(ffull), DW'(mq.size() == DEPTH));
    chk("R5 ovr_err", DW'(ovr_err), DW'(m_ovr));
    chk({et, " frm_err"}, DW'(frm_err), DW'(m_err[0]));
    chk({et, " par_err"}, DW'(par_err), DW'(m_err[1]));
    chk({et, " brk_err"}, DW'(brk_err), DW'(m_err[2]));
  endtask

  task automatic step(input bit v, input logic [DW-1:0] d, input bit f, input bit pe,
                      input bit b, input bit rd, input bit clr);
    cmp_valid = v; cmp_data = d; cmp_frm = f; cmp_par = pe; cmp_brk = b;
    rd_en = rd; err_clr = clr;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11: reset state
    chk("R11 rd_data", rd_data, '0);
    chk("R11 status", DW'({rxrdy, ffull, ovr_err, frm_err, par_err, brk_err}), '0);

    // R10: empty read changes nothing
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R10 rd_data", rd_data, 8'h00);
    chk("R10 rxrdy", DW'(rxrdy), 8'h00);

    // fill, then hold, then overrun (R4)
    step(1, 8'h11, 1, 0, 0, 0, 0);
    chk("R6 frm head", DW'(frm_err), 8'h01);
    step(1, 8'h22, 0, 0, 0, 0, 0);
    step(1, 8'h33, 0, 1, 0, 0, 0);
    chk("R3 full", DW'(ffull), 8'h01);
    step(1, 8'h44, 0, 0, 0, 0, 0);
    chk("R4 wait no ovr", DW'(ovr_err), 8'h00);
    step(1, 8'h55, 0, 0, 0, 0, 0);
    chk("R4 ovr", DW'(ovr_err), 8'h01);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R1 first out", rd_data, 8'h11);
    chk("R3 full kept", DW'(ffull), 8'h01);
    chk("R6 frm next head", DW'(frm_err), 8'h00);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R6 par head", DW'(par_err), 8'h01);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R1 third out", rd_data, 8'h33);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R4 lost char replaced", rd_data, 8'h55);
    chk("R2 empty", DW'(rxrdy), 8'h00);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    chk("R10 empty read keeps", rd_data, 8'h55);
    chk("R5 ovr stays", DW'(ovr_err), 8'h01);

    // block mode: clear with simultaneous error (R9)
    block_mode = 1'b1;
    step(1, 8'h66, 1, 0, 0, 0, 1);
    chk("R9 frm wins clear", DW'(frm_err), 8'h01);
    chk("R5 ovr cleared", DW'(ovr_err), 8'h00);
    step(1, 8'h77, 0, 0, 0, 0, 0);
    chk("R7 frm sticky", DW'(frm_err), 8'h01);
    parity_en = 1'b0;
    step(1, 8'h88, 0, 1, 0, 0, 1);
    chk("R8 parity gated", DW'(par_err), 8'h00);
    parity_en = 1'b1;

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      block_mode = ph[0];
      parity_en = ($urandom % 4) != 0;
      for (int i = 0; i < 600; i++) begin
        step(($urandom % 10) < 4, DW'($urandom), ($urandom % 5) == 0,
             ($urandom % 5) == 0, ($urandom % 7) == 0,
             ($urandom % 20) < 7, ($urandom % 25) == 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule